// File: doc/BRIEF.md
# Bit-Banged GPIO Port Controller

A register-mapped general-purpose I/O block with two ports, A and D. Each port owns a data-out register, an output-enable register and a read-only data-in view. A CPU reaches the block over a plain strobe bus. The bus carries byte addresses, and the block drops the two low bits to form a word index. The register window holds a fixed number of 32-bit words. Every in-window index that is not a port register is plain storage.

Some bits of port A have fixed uses. They drive the address-latch, command-latch and chip-enable strobes of a NAND flash device, and the device's ready line shows up in the port A data-in view. Port D carries a software-driven serial link to a temperature sensor: one bit is the serial clock, one is the data sent to the sensor, and the sensor's reply shows up in the port D data-in view. When a port D data-out write changes the clock bit, the block raises a one-cycle clock-edge event whose direction is the new clock level.

The bus side is a small state machine with two states. `BUS_IDLE` means no read data is pending. `BUS_RESP` means read data is valid on this cycle. The transition *read-issue* (IDLE→RESP, RESP→RESP) is taken whenever the read strobe is high. The transition *read-retire* (RESP→IDLE) is taken when it is low.

Top module: `gpio_bitbang_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every register to zero. While in reset and after it, all pin outputs, `bus_rvalid`, `sensor_edge` and `sensor_edge_rise` are 0 until a write changes them, and every in-window storage index reads 0.
- R2: `bus_rvalid` is high in exactly the cycle after a cycle with `bus_rd` high. `bus_rdata` then holds the value selected at that read edge. A read in the same cycle as a write returns the value from before the write.
- R3: The word index is `bus_addr >> 2`, so the two low address bits are ignored. The window holds WINDOW_BYTES/4 words, which is indices 0 to 22 by default. A write outside the window changes nothing, and a read outside the window returns 0.
- R4: A write at any in-window index other than 0x01 and 0x11 stores the full data word on the write edge, and a later read of that index returns it.
- R5: Reading index 0x01 (port A data-in) returns (word 0x00 AND word 0x02) OR (`flash_ready` << 7).
- R6: Reading index 0x11 (port D data-in) returns (word 0x10 AND word 0x12) OR (`sensor_sdo` << 4).
- R7: Bits 6, 5 and 4 of word 0x00 drive `flash_ale`, `flash_cle` and `flash_ce`. These outputs change on the edge of the write.
- R8: Bit 1 of word 0x10 drives `sensor_sck` and bit 4 drives `sensor_sdi`. These outputs change on the edge of the write.
- R9: A write to index 0x10 whose bit 1 differs from the stored bit 1 makes `sensor_edge` high for the following cycle only. On that edge `sensor_edge_rise` takes the new bit 1 and then holds it. Any other write leaves `sensor_edge` low.
- R10: Writes to index 0x01 or 0x11 are ignored. The data-in view afterwards still follows R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| flash_ready | input | 1 | Flash ready/busy line |
| flash_ale | output | 1 | Flash address-latch strobe |
| flash_cle | output | 1 | Flash command-latch strobe |
| flash_ce | output | 1 | Flash chip enable |
| sensor_sdo | input | 1 | Serial data from sensor |
| sensor_sck | output | 1 | Serial clock to sensor |
| sensor_sdi | output | 1 | Serial data to sensor |
| sensor_edge | output | 1 | One-cycle clock-edge event |
| sensor_edge_rise | output | 1 | Direction of the last edge (1 = rising) |

## Verification
The bench builds the block with its default parameters: 32-bit data, an 8-bit byte address and a 92-byte window. Since the 8-bit address covers 256 bytes, indices 23 to 63 are reachable, so the bench can hit writes and reads that fall just past the window end as well as far beyond it. With 23 words, the last storage index (0x16) and the neighbours of both data-in indices can all be exercised, alongside a long pseudo-random mix of writes and reads that toggles the serial clock bit.

// File: rtl/gpio_bb_pkg.sv
package gpio_bb_pkg;
    // Word indices whose decoding the attached devices rely on
    localparam int unsigned IDX_A_OUT = 'h00;
    localparam int unsigned IDX_A_IN  = 'h01;
    localparam int unsigned IDX_A_OE  = 'h02;
    localparam int unsigned IDX_D_OUT = 'h10;
    localparam int unsigned IDX_D_IN  = 'h11;
    localparam int unsigned IDX_D_OE  = 'h12;

    // Bit positions inside the port words
    localparam int unsigned A_CE_BIT  = 4;
    localparam int unsigned A_CLE_BIT = 5;
    localparam int unsigned A_ALE_BIT = 6;
    localparam int unsigned A_RDY_BIT = 7;
    localparam int unsigned D_SCK_BIT = 1;
    localparam int unsigned D_SDI_BIT = 4;
    localparam int unsigned D_SDO_BIT = 4;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_bb_regfile.sv
module gpio_bb_regfile
    import gpio_bb_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 23,
    parameter int unsigned IDX_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [WORDS-1:0][DATA_W-1:0] words_q
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == IDX_A_IN || g == IDX_D_IN) begin : g_view
            // data-in positions hold no state; writes fall away
            assign words_q[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    q <= wr_data;
                end
            end
            assign words_q[g] = q;
        end
    end
endmodule

// File: rtl/gpio_bb_read_mux.sv
module gpio_bb_read_mux
    import gpio_bb_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 23,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [WORDS-1:0][DATA_W-1:0] words_q,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic                         in_window,
    input  logic                         flash_ready,
    input  logic                         sensor_sdo,
    output logic [DATA_W-1:0]            rd_value
);
    logic [DATA_W-1:0] port_a_view;
    logic [DATA_W-1:0] port_d_view;

    always_comb begin
        port_a_view = words_q[IDX_A_OUT] & words_q[IDX_A_OE];
        port_a_view[A_RDY_BIT] = port_a_view[A_RDY_BIT] | flash_ready;
        port_d_view = words_q[IDX_D_OUT] & words_q[IDX_D_OE];
        port_d_view[D_SDO_BIT] = port_d_view[D_SDO_BIT] | sensor_sdo;
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < int'(WORDS); i++) begin
            if (in_window && rd_idx == IDX_W'(i)) begin
                if (i == int'(IDX_A_IN)) begin
                    rd_value = port_a_view;
                end else if (i == int'(IDX_D_IN)) begin
                    rd_value = port_d_view;
                end else begin
                    rd_value = words_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bb_sck_edge.sv
module gpio_bb_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic old_sck,
    input  logic new_sck,
    output logic edge_pulse,
    output logic edge_rise
);
    logic toggles;
    assign toggles = wr_hit && (old_sck != new_sck);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_pulse <= 1'b0;
            edge_rise  <= 1'b0;
        end else begin
            edge_pulse <= toggles;
            if (toggles) begin
                edge_rise <= new_sck;
            end
        end
    end
endmodule

// File: rtl/gpio_bitbang_ctrl.sv
module gpio_bitbang_ctrl
    import gpio_bb_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned WINDOW_BYTES = 92
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              flash_ready,
    output logic              flash_ale,
    output logic              flash_cle,
    output logic              flash_ce,
    input  logic              sensor_sdo,
    output logic              sensor_sck,
    output logic              sensor_sdi,
    output logic              sensor_edge,
    output logic              sensor_edge_rise
);
    localparam int unsigned WORDS = WINDOW_BYTES / 4;
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]             word_idx;
    logic                         in_window;
    logic                         wr_ok;
    logic [WORDS-1:0][DATA_W-1:0] words_q;
    logic [DATA_W-1:0]            rd_value;
    bus_state_e                   state_q, state_d;

    assign word_idx  = bus_addr[ADDR_W-1:2];
    assign in_window = (32'(word_idx) < WORDS);
    assign wr_ok     = bus_wr && in_window;

    gpio_bb_regfile #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_idx  (word_idx),
        .wr_data (bus_wdata),
        .words_q (words_q)
    );

    gpio_bb_read_mux #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_rmux (
        .words_q     (words_q),
        .rd_idx      (word_idx),
        .in_window   (in_window),
        .flash_ready (flash_ready),
        .sensor_sdo  (sensor_sdo),
        .rd_value    (rd_value)
    );

    gpio_bb_sck_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_ok && word_idx == IDX_W'(IDX_D_OUT)),
        .old_sck    (words_q[IDX_D_OUT][D_SCK_BIT]),
        .new_sck    (bus_wdata[D_SCK_BIT]),
        .edge_pulse (sensor_edge),
        .edge_rise  (sensor_edge_rise)
    );

    // Bus state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_rd)  state_d = BUS_RESP;
            BUS_RESP: if (!bus_rd) state_d = BUS_IDLE;
            default:               state_d = BUS_IDLE;
        endcase
    end

    // Read data captured on the read-issue transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_value;
        end
    end

    // Outputs
    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        flash_ale  = words_q[IDX_A_OUT][A_ALE_BIT];
        flash_cle  = words_q[IDX_A_OUT][A_CLE_BIT];
        flash_ce   = words_q[IDX_A_OUT][A_CE_BIT];
        sensor_sck = words_q[IDX_D_OUT][D_SCK_BIT];
        sensor_sdi = words_q[IDX_D_OUT][D_SDI_BIT];
    end
endmodule

// File: rtl/gpio_bb_checker.sv
module gpio_bb_checker #(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned WINDOW_BYTES = 92
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              flash_ale,
    input logic              flash_ce,
    input logic              sensor_sck,
    input logic              sensor_sdi,
    input logic              sensor_edge,
    input logic              sensor_edge_rise
);
    localparam int unsigned WORDS = WINDOW_BYTES / 4;

    assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_only_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    assert_outside_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && 32'(bus_addr[ADDR_W-1:2]) >= WORDS) |=> (bus_rdata == '0));

    assert_ale_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1:2] == '0) |=> (flash_ale == $past(bus_wdata[6])));

    assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(sensor_sck) && $stable(sensor_sdi) && $stable(flash_ce)));

    assert_edge_means_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_edge |-> (sensor_sck != $past(sensor_sck)));

    assert_edge_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_edge |-> (sensor_edge_rise == sensor_sck));
endmodule

bind gpio_bitbang_ctrl gpio_bb_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .flash_ale(flash_ale), .flash_ce(flash_ce),
    .sensor_sck(sensor_sck), .sensor_sdi(sensor_sdi),
    .sensor_edge(sensor_edge), .sensor_edge_rise(sensor_edge_rise)
);

// File: tb/sim_gpio_bitbang_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bitbang_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flash_ready = 1'b0;
    logic        flash_ale, flash_cle, flash_ce;
    logic        sensor_sdo = 1'b0;
    logic        sensor_sck, sensor_sdi, sensor_edge, sensor_edge_rise;

    always #2 clk = ~clk;

    gpio_bitbang_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .flash_ready(flash_ready),
        .flash_ale(flash_ale), .flash_cle(flash_cle), .flash_ce(flash_ce),
        .sensor_sdo(sensor_sdo), .sensor_sck(sensor_sck),
        .sensor_sdi(sensor_sdi), .sensor_edge(sensor_edge),
        .sensor_edge_rise(sensor_edge_rise)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference model
    logic [31:0] mw [0:63];
    logic        e_rvalid, e_edge, e_rise;
    logic [31:0] e_rdata;
    string       rd_tag = "R2";
    string       e_tag  = "R2";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input int idx);
        logic [31:0] v;
        if (idx >= 23) return 32'h0;
        if (idx == 1) begin
            v = mw[0] & mw[2];
            v[7] = v[7] | flash_ready;
            return v;
        end
        if (idx == 17) begin
            v = mw[16] & mw[18];
            v[4] = v[4] | sensor_sdo;
            return v;
        end
        return mw[idx];
    endfunction

    always @(posedge clk) begin
        int idx;
        string ptag;
        idx = int'(bus_addr >> 2);
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mw[i] = '0;
            e_rvalid = 0; e_rdata = '0; e_edge = 0; e_rise = 0;
        end else begin
            if (bus_rd) begin
                e_rdata = model_read(idx);
                e_tag = rd_tag;
            end
            e_rvalid = bus_rd;
            e_edge = 0;
            if (bus_wr && idx < 23 && idx != 1 && idx != 17) begin
                if (idx == 16 && bus_wdata[1] != mw[16][1]) begin
                    e_edge = 1;
                    e_rise = bus_wdata[1];
                end
                mw[idx] = bus_wdata;
            end
        end
        #1;
        ptag = rst_n ? "R2" : "R1";
        chk(ptag, 32'(bus_rvalid), 32'(e_rvalid));
        if (e_rvalid) chk(e_tag, bus_rdata, e_rdata);
        ptag = rst_n ? "R7" : "R1";
        chk(ptag, {29'b0, flash_ale, flash_cle, flash_ce}, {29'b0, mw[0][6], mw[0][5], mw[0][4]});
        ptag = rst_n ? "R8" : "R1";
        chk(ptag, {30'b0, sensor_sck, sensor_sdi}, {30'b0, mw[16][1], mw[16][4]});
        ptag = rst_n ? "R9" : "R1";
        chk(ptag, {30'b0, sensor_edge, sensor_edge_rise}, {30'b0, e_edge, e_rise});
    end

    task automatic op(input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; rd_tag = tag;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1, 0, a, d, "R2");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        op(0, 1, a, 32'h0, tag);
    endtask

    task automatic idle();
        op(0, 0, 8'h00, 32'h0, "R2");
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: every in-window index reads zero after reset
        for (int i = 0; i < 23; i++) rd(8'(i * 4), "R1");
        idle();
        // R7: flash strobes
        wr(8'h00, 32'h0000_0070);
        wr(8'h00, 32'h0000_0020);
        wr(8'h00, 32'h0000_0050);
        // R5: port A data-in merge
        rd(8'h04, "R5");
        flash_ready = 1'b1;
        idle();
        rd(8'h04, "R5");
        wr(8'h08, 32'h0000_00FF);
        wr(8'h00, 32'h0000_005A);
        rd(8'h04, "R5");
        wr(8'h08, 32'h0000_000F);
        rd(8'h04, "R5");
        // R10: writes to data-in views ignored
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, "R10");
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, "R10");
        // R9/R8: serial clock edges
        wr(8'h40, 32'h0000_0002);
        wr(8'h40, 32'h0000_0002);
        wr(8'h40, 32'h0000_0010);
        idle();
        wr(8'h40, 32'h0000_0012);
        wr(8'h40, 32'h0000_0000);
        // R6: port D data-in merge
        sensor_sdo = 1'b1;
        idle();
        rd(8'h44, "R6");
        wr(8'h48, 32'h0000_00FF);
        wr(8'h40, 32'h0000_0006);
        rd(8'h44, "R6");
        sensor_sdo = 1'b0;
        idle();
        rd(8'h44, "R6");
        // R4 / R3: storage, low address bits, window end
        wr(8'h14, 32'hDEAD_BEEF);
        rd(8'h17, "R3");
        rd(8'h14, "R4");
        wr(8'h58, 32'h1234_5678);
        rd(8'h58, "R4");
        wr(8'h5C, 32'hCAFE_F00D);
        rd(8'h5C, "R3");
        wr(8'hFC, 32'hCAFE_F00D);
        rd(8'hFC, "R3");
        rd(8'h58, "R3");
        // R2: back-to-back reads, and read with write in same cycle
        rd(8'h14, "R2");
        rd(8'h58, "R2");
        op(1, 1, 8'h14, 32'h0BAD_0BAD, "R2");
        rd(8'h14, "R4");
        // Mixed pseudo-random traffic
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            flash_ready = lfsr[9];
            sensor_sdo  = lfsr[13];
            op(lfsr[0], lfsr[1], {lfsr[7:6] == 2'b00 ? 2'b00 : 2'b01, lfsr[5:2], lfsr[11:10]},
               {lfsr[15:0], lfsr[31:16]}, "R4");
        end
        idle();
        idle();
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule